// File: doc/BRIEF.md
# Real-Time Clock Seconds Counter

This block keeps a 32-bit count of seconds. A slow 32.768 kHz reference comes in on a single pin. It is brought into the fast system clock domain, and its rising edges are counted. After a set number of edges (32768 by default), one tick reaches the seconds counter. The counter moves up by one on each tick while the enable input is high. When enable is low, the counter and the partial prescale count hold still.

After reset the counter holds 1, so the first enable starts counting from 1. Software can put a new value into the counter through a load strobe. A match register, written through its own strobe, names the count that raises an event. When the counter steps onto that value, a raw flag latches and a one-cycle match pulse goes out for a DMA requester. Counting goes on past the match, and from all ones it wraps to zero. An interrupt mask gates the raw flag onto a masked flag and an interrupt line. A write-one clear strobe drops the raw flag. A debug stall input, which freezes other timers, has no effect on this counter.

Top module: `rtc_sec_counter`

## Requirements
- R1: After reset, `count` is 1 and `raw_flag`, `masked_flag`, `irq` and `match_evt` are all 0.
- R2: While `enable` is 1, `count` goes up by exactly one for every PRESCALE rising edges of `ref_in`. How long `ref_in` stays high does not matter. While `enable` is 0, `count` holds, and the partial edge count is discarded, so counting restarts from zero edges when `enable` returns.
- R3: A cycle with `load_we` = 1 sets `count` to `load_val` on the next clock edge, and this takes precedence over a tick in the same cycle.
- R4: When a tick moves `count` onto the value last written by `match_we`/`match_val`, two things happen in the cycle the new count appears: `raw_flag` becomes 1, and `match_evt` is 1 for exactly that one cycle. Counting continues afterwards.
- R5: A tick with `count` = 32'hFFFF_FFFF gives `count` = 0, and the ticks after that count up from 0.
- R6: An `int_clr` pulse clears `raw_flag` on the next edge. If a match sets the flag in the same cycle as the clear, the flag stays 1.
- R7: `masked_flag` and `irq` both equal `raw_flag` AND `int_mask`.
- R8: `stall_req` has no effect on counting, prescaling or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | 32.768 kHz reference, asynchronous to `clk` |
| enable | input | 1 | Counter run enable |
| stall_req | input | 1 | Debug freeze request (ignored) |
| load_we | input | 1 | Load strobe for the counter |
| load_val | input | 32 | Value to load into the counter |
| match_we | input | 1 | Write strobe for the match register |
| match_val | input | 32 | New match value |
| int_mask | input | 1 | Interrupt mask (1 = pass) |
| int_clr | input | 1 | Write-one clear of the raw flag |
| count | output | 32 | Current seconds count |
| raw_flag | output | 1 | Latched match flag |
| masked_flag | output | 1 | Raw flag gated by the mask |
| irq | output | 1 | Interrupt request |
| match_evt | output | 1 | One-cycle match pulse for DMA |

## Verification
The bench shortens the prescaler to four edges. It goes after four corner cases:
- The count after reset and on the first tick. A design that reset the counter to zero would read 0 and then 1 where 1 and then 2 are expected.
- The rollover from all ones. A counter that saturated, or that stopped at the match, would leave the count stuck.
- A clear strobe placed exactly on the tick edge that makes a match. A design that let the clear win would lose that event and show no raw flag.
- Disabling the counter partway through a prescale period, and stalling while running. A prescaler that kept its partial count would tick early. A counter that honoured the stall would fall behind the bench's count of edges.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_W = 32;
  typedef logic [RTC_W-1:0] rtc_word_t;

  // Value after one seconds tick; all ones rolls to zero.
  function automatic rtc_word_t rtc_step(input rtc_word_t cur);
    return cur + rtc_word_t'(1);
  endfunction

  // True when the prescale counter sits on its final edge.
  function automatic logic rtc_last_edge(input int unsigned pc, input int unsigned limit);
    return (pc == limit - 1);
  endfunction
endpackage

// File: rtl/rtc_ref_sync.sv
module rtc_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768,
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rise,
  output logic tick
);
  import rtc_pkg::*;
  logic [PS_W-1:0] pc;
  logic            last;

  assign last = rtc_last_edge(int'(pc), PRESCALE);
  assign tick = run & rise & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= '0;
    else if (!run)     pc <= '0;
    else if (rise) begin
      if (last) pc <= '0;
      else      pc <= pc + PS_W'(1);
    end
  end
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      advance,
  input  logic      load_we,
  input  rtc_word_t load_val,
  input  logic      match_we,
  input  rtc_word_t match_val,
  output rtc_word_t count,
  output logic      hit
);
  rtc_word_t match_q;
  rtc_word_t nxt;

  assign nxt = rtc_step(count);
  assign hit = advance & ~load_we & (nxt == match_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= rtc_word_t'(1);
    else if (load_we) count <= load_val;
    else if (advance) count <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        match_q <= '0;
    else if (match_we) match_q <= match_val;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic mask,
  output logic raw,
  output logic masked,
  output logic evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   raw <= 1'b0;
    else if (hit) raw <= 1'b1;
    else if (clr) raw <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= hit;
  end

  assign masked = raw & mask;
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int PRESCALE    = 32768,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_in,
  input  logic        enable,
  input  logic        stall_req,
  input  logic        load_we,
  input  logic [31:0] load_val,
  input  logic        match_we,
  input  logic [31:0] match_val,
  input  logic        int_mask,
  input  logic        int_clr,
  output logic [31:0] count,
  output logic        raw_flag,
  output logic        masked_flag,
  output logic        irq,
  output logic        match_evt
);
  logic ref_rise;
  logic tick;
  logic advance;
  logic hit;

  rtc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise_o(ref_rise)
  );

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(enable), .rise(ref_rise), .tick(tick)
  );

  // stall_req deliberately takes no part in the advance decision.
  assign advance = tick;

  rtc_sec_core u_core (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .load_we(load_we), .load_val(load_val),
    .match_we(match_we), .match_val(match_val),
    .count(count), .hit(hit)
  );

  rtc_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(int_clr), .mask(int_mask),
    .raw(raw_flag), .masked(masked_flag), .evt(match_evt)
  );

  assign irq = masked_flag;
endmodule

// File: rtl/rtc_sec_counter_chk.sv
module rtc_sec_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        stall_req,
  input logic        advance,
  input logic        hit,
  input logic        load_we,
  input logic [31:0] load_val,
  input logic        int_clr,
  input logic        int_mask,
  input logic [31:0] count,
  input logic        raw_flag,
  input logic        irq,
  input logic        match_evt
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load_we |=> count == $past(count) + 32'd1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance && !load_we |=> $stable(count));
  assert_run_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> enable);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> count == $past(load_val));
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw_flag && match_evt);
  assert_evt_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load_we && count == 32'hFFFF_FFFF |=> count == 32'd0);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr && !hit |=> !raw_flag);
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_mask && raw_flag);
  assert_no_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req && advance && !load_we |=> count != $past(count));
endmodule

bind rtc_sec_counter rtc_sec_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .stall_req(stall_req),
  .advance(advance), .hit(hit), .load_we(load_we), .load_val(load_val),
  .int_clr(int_clr), .int_mask(int_mask), .count(count),
  .raw_flag(raw_flag), .irq(irq), .match_evt(match_evt)
);

// File: tb/tb_rtc_sec_counter.sv
module tb_rtc_sec_counter;
  localparam int PS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0, enable = 1'b0, stall_req = 1'b0;
  logic        load_we = 1'b0, match_we = 1'b0, int_mask = 1'b0, int_clr = 1'b0;
  logic [31:0] load_val = '0, match_val = '0;
  logic [31:0] count;
  logic        raw_flag, masked_flag, irq, match_evt;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_cnt, m_match;
  int          m_pc;
  bit          m_en, m_raw, m_mask;

  always #4 clk = ~clk;

  rtc_sec_counter #(.PRESCALE(PS)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .enable(enable),
    .stall_req(stall_req), .load_we(load_we), .load_val(load_val),
    .match_we(match_we), .match_val(match_val), .int_mask(int_mask),
    .int_clr(int_clr), .count(count), .raw_flag(raw_flag),
    .masked_flag(masked_flag), .irq(irq), .match_evt(match_evt)
  );

  function automatic bit exp_gated(input bit raw, input bit mask);
    return raw && mask;
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] c);
    return (c == 32'hFFFF_FFFF) ? 32'd0 : c + 32'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(count == m_cnt, req, count, m_cnt);
    chk(raw_flag == m_raw, req, 32'(raw_flag), 32'(m_raw));
    chk(masked_flag == exp_gated(m_raw, m_mask), {req, "/R7"}, 32'(masked_flag), 32'(exp_gated(m_raw, m_mask)));
    chk(irq == exp_gated(m_raw, m_mask), {req, "/R7"}, 32'(irq), 32'(exp_gated(m_raw, m_mask)));
  endtask

  // One reference period; optional clear strobe lands on the tick edge.
  task automatic ref_pulse(input bit clr_on_edge, input string req);
    int evt_seen = 0;
    bit hit = 0;
    ref_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i == 2 && clr_on_edge) int_clr = 1'b1;
      if (i == 4) ref_in = 1'b0;
      @(negedge clk);
      if (i == 2) int_clr = 1'b0;
      if (match_evt) evt_seen++;
    end
    if (m_en) begin
      if (m_pc == PS - 1) begin
        m_pc = 0;
        m_cnt = exp_next(m_cnt);
        if (m_cnt == m_match) begin hit = 1; m_raw = 1; end
      end else m_pc++;
    end
    if (clr_on_edge && !hit) m_raw = 0;
    chk(evt_seen == int'(hit), {req, "/R4 evt"}, 32'(evt_seen), 32'(hit));
    check_state(req);
  endtask

  task automatic do_load(input logic [31:0] v);
    load_we = 1'b1; load_val = v;
    @(negedge clk);
    load_we = 1'b0;
    m_cnt = v;
  endtask

  task automatic do_match(input logic [31:0] v);
    match_we = 1'b1; match_val = v;
    @(negedge clk);
    match_we = 1'b0;
    m_match = v;
  endtask

  task automatic do_clear();
    int_clr = 1'b1;
    @(negedge clk);
    int_clr = 1'b0;
    m_raw = 0;
  endtask

  task automatic set_en(input bit e);
    enable = e; m_en = e;
    if (!e) m_pc = 0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n * PS; i++) ref_pulse(1'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 32'd1; m_match = 32'd0; m_pc = 0; m_en = 0; m_raw = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_state("R1");
    chk(match_evt == 1'b0, "R1 evt", 32'(match_evt), 32'd0);

    // R2: first tick from 1 to 2, pulses while disabled do nothing
    ticks(2, "R2 disabled");
    set_en(1);
    ticks(1, "R2 first");
    ref_pulse(0, "R2 partial"); ref_pulse(0, "R2 partial");
    set_en(0); set_en(1);
    ticks(1, "R2 restart");

    // R4/R7: match with mask, counting continues
    int_mask = 1'b1; m_mask = 1;
    do_match(m_cnt + 32'd1);
    ticks(2, "R4");
    do_clear();
    check_state("R6 clear");

    // R6: clear on the same edge as a match keeps the flag
    do_match(m_cnt + 32'd1);
    for (int i = 0; i < PS - 1; i++) ref_pulse(0, "R6 pre");
    ref_pulse(1, "R6 set wins");

    // R5: wraparound
    do_load(32'hFFFF_FFFE);
    check_state("R3 load");
    ticks(3, "R5 wrap");

    // R8: stall ignored
    stall_req = 1'b1;
    ticks(2, "R8 stall");
    stall_req = 1'b0;

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int sel = int'($urandom_range(0, 99));
      if (sel < 55)      ref_pulse($urandom_range(0, 7) == 0, "R2 rand");
      else if (sel < 62) set_en(~m_en);
      else if (sel < 70) do_load(($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF - $urandom_range(0, 2) : $urandom);
      else if (sel < 80) do_match(m_cnt + $urandom_range(1, 3));
      else if (sel < 87) do_clear();
      else if (sel < 94) begin
        m_mask = ~m_mask; int_mask = m_mask; @(negedge clk);
      end else begin
        stall_req = ~stall_req; @(negedge clk);
      end
      check_state("R3 rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule